// File: doc/BRIEF.md
# Firmware Call and Return Sequencer

This block steers the control flow of a processor core when the core enters or leaves its privileged firmware mode. It has three kinds of entry into and exit from that mode. A firmware call is a numbered request that sends execution to a fixed slot inside the firmware image. An interrupt entry sends execution to a vector offset from the same image base. A return leaves the firmware. The block keeps the state that these transitions share: the firmware image base, the saved exception address, the privileged-mode flag, the interrupt flag and the load-lock address.

Each request is a single-cycle pulse. The block resolves the request at the next clock edge. It then presents a one-cycle `redirect` strobe together with the new fetch address, and updates its state registers at that same edge. Two small read-modify-write operations on the interrupt flag can run alongside any transition: a read-and-clear and a read-and-set. Each one reports the old flag value to a destination register index. Index 31 acts as a discard sink.

Top module: `fwcall_seq`

## Requirements
- R1: After reset, `priv_mode` is 1, `intr_flag` is 0, `lock_addr` is all ones, and `redirect`, `exc_addr`, `fw_base` and `rx_wen` are 0.
- R2: A firmware call with code c redirects to `fw_base + 0x2000 + (c-0x80)*64` when bit 7 of c is 1, and to `fw_base + 0x1000 + c*64` when bit 7 is 0.
- R3: A firmware call loads `exc_addr` with `cur_pc` ORed in bit 0 with the value `priv_mode` had before the call.
- R4: A firmware call leaves `priv_mode` at 1, whatever its previous value.
- R5: A return redirects to the target with bits 1:0 cleared, and loads `priv_mode` from bit 0 of the target.
- R6: A return clears `intr_flag` and sets `lock_addr` to all ones. This overrides a lock load in the same cycle.
- R7: When `ret_legacy` is 1, a return takes its target from `exc_addr` and ignores `ret_target`.
- R8: An interrupt entry redirects to `fw_base + irq_vec` and sets `priv_mode` to 1. It leaves `exc_addr`, `intr_flag` and `lock_addr` unchanged.
- R9: A flag operation (`rx_req`) presents the old `intr_flag` on `rx_data` one cycle later. It then writes `intr_flag` with `rx_set`: 1 for read-and-set, 0 for read-and-clear. `rx_wen` is 1 with the result unless `rx_dst` is 31.
- R10: When requests coincide, interrupt entry wins over a call, and a call wins over a return. A losing request has no effect on any output.
- R11: A flag operation that falls in the same cycle as a return reports the old flag, and `intr_flag` ends at 0.
- R12: `base_we` loads `fw_base` from `base_din`. `lock_we` loads `lock_addr` from `lock_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | XLEN | PC of the requesting instruction |
| call_req | input | 1 | Firmware call pulse |
| call_code | input | 8 | Firmware function code |
| ret_req | input | 1 | Return pulse |
| ret_legacy | input | 1 | Return target comes from the saved exception address |
| ret_target | input | XLEN | Return target operand; bit 0 is the new mode |
| irq_req | input | 1 | Interrupt entry pulse |
| irq_vec | input | VOFFW | Interrupt vector offset from the base |
| rx_req | input | 1 | Interrupt-flag read-modify-write pulse |
| rx_set | input | 1 | Value written to the flag (1 set, 0 clear) |
| rx_dst | input | 5 | Destination register index; 31 discards |
| base_we | input | 1 | Firmware base load |
| base_din | input | XLEN | Firmware base value |
| lock_we | input | 1 | Lock address load |
| lock_din | input | XLEN | Lock address value |
| redirect | output | 1 | New fetch address valid |
| redirect_pc | output | XLEN | New fetch address |
| exc_addr | output | XLEN | Saved exception address |
| priv_mode | output | 1 | Privileged firmware mode flag |
| intr_flag | output | 1 | Interrupt flag |
| lock_addr | output | XLEN | Load-lock address |
| fw_base | output | XLEN | Firmware image base |
| rx_wen | output | 1 | Flag operation result is written back |
| rx_data | output | 1 | Old interrupt flag value |
| rx_dst_q | output | 5 | Destination index of the result |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a return and an interrupt-flag operation, since both write the flag. The second is a return and a lock load, since both write the lock address. The bench raises the flag first, then pulses a return together with a read-and-set. It expects the old value 1 on `rx_data` and a flag of 0 afterwards. A lock load that lands on a return must leave the lock at all ones. The bench also provokes each pairing of transition requests and judges that only the winner changes the PC, the mode, the exception address and the lock.

// File: rtl/fwcall_seq.sv
module fwcall_seq #(
  parameter int XLEN  = 64,
  parameter int VOFFW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic             call_req,
  input  logic [7:0]       call_code,
  input  logic             ret_req,
  input  logic             ret_legacy,
  input  logic [XLEN-1:0]  ret_target,
  input  logic             irq_req,
  input  logic [VOFFW-1:0] irq_vec,
  input  logic             rx_req,
  input  logic             rx_set,
  input  logic [4:0]       rx_dst,
  input  logic             base_we,
  input  logic [XLEN-1:0]  base_din,
  input  logic             lock_we,
  input  logic [XLEN-1:0]  lock_din,
  output logic             redirect,
  output logic [XLEN-1:0]  redirect_pc,
  output logic [XLEN-1:0]  exc_addr,
  output logic             priv_mode,
  output logic             intr_flag,
  output logic [XLEN-1:0]  lock_addr,
  output logic [XLEN-1:0]  fw_base,
  output logic             rx_wen,
  output logic             rx_data,
  output logic [4:0]       rx_dst_q
);

  localparam logic [XLEN-1:0] LO_SLOT = XLEN'(32'h1000);
  localparam logic [XLEN-1:0] HI_SLOT = XLEN'(32'h2000);
  localparam logic [4:0]      SINK    = 5'd31;

  logic            do_irq, do_call, do_ret;
  logic [XLEN-1:0] slot_off, call_pc, ret_val, next_pc;

  assign do_irq  = irq_req;
  assign do_call = call_req & ~irq_req;
  assign do_ret  = ret_req & ~irq_req & ~call_req;

  assign slot_off = (call_code[7] ? HI_SLOT : LO_SLOT) + XLEN'({call_code[6:0], 6'b0});
  assign call_pc  = fw_base + slot_off;
  assign ret_val  = ret_legacy ? exc_addr : ret_target;

  always_comb begin
    if (do_irq)       next_pc = fw_base + XLEN'(irq_vec);
    else if (do_call) next_pc = call_pc;
    else              next_pc = {ret_val[XLEN-1:2], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      exc_addr    <= '0;
      priv_mode   <= 1'b1;
      intr_flag   <= 1'b0;
      lock_addr   <= '1;
      fw_base     <= '0;
      rx_wen      <= 1'b0;
      rx_data     <= 1'b0;
      rx_dst_q    <= '0;
    end else begin
      redirect <= do_irq | do_call | do_ret;
      if (do_irq | do_call | do_ret) redirect_pc <= next_pc;

      if (do_call) exc_addr <= {cur_pc[XLEN-1:1], cur_pc[0] | priv_mode};

      if (do_irq | do_call) priv_mode <= 1'b1;
      else if (do_ret)      priv_mode <= ret_val[0];

      if (do_ret)      intr_flag <= 1'b0;
      else if (rx_req) intr_flag <= rx_set;

      if (do_ret)       lock_addr <= '1;
      else if (lock_we) lock_addr <= lock_din;

      if (base_we) fw_base <= base_din;

      rx_wen   <= rx_req && (rx_dst != SINK);
      rx_data  <= intr_flag;
      rx_dst_q <= rx_dst;
    end
  end

  // R3
  call_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !irq_req) |=> (exc_addr == ($past(cur_pc) | XLEN'($past(priv_mode)))));

  // R4
  call_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !irq_req) |=> (priv_mode && redirect));

  // R5
  ret_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !irq_req) |=>
      (redirect_pc[1:0] == 2'b00 &&
       priv_mode == ($past(ret_legacy) ? $past(exc_addr[0]) : $past(ret_target[0]))));

  // R6
  ret_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req && !irq_req) |=> ((&lock_addr) && !intr_flag));

  // R8
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> (priv_mode && redirect && $stable(exc_addr)));

  // R9
  rx_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_dst == 5'd31) |=> !rx_wen);

  // R9
  rx_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |=> (rx_data == $past(intr_flag)));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !call_req && !ret_req) |=> (!redirect && $stable(priv_mode)));

endmodule

// File: tb/fwcall_seq_test.sv
module fwcall_seq_test;
  localparam int XLEN  = 64;
  localparam int VOFFW = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [XLEN-1:0]  cur_pc, ret_target, base_din, lock_din;
  logic             call_req, ret_req, ret_legacy, irq_req, rx_req, rx_set, base_we, lock_we;
  logic [7:0]       call_code;
  logic [VOFFW-1:0] irq_vec;
  logic [4:0]       rx_dst;
  logic             redirect, priv_mode, intr_flag, rx_wen, rx_data;
  logic [XLEN-1:0]  redirect_pc, exc_addr, lock_addr, fw_base;
  logic [4:0]       rx_dst_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fwcall_seq #(.XLEN(XLEN), .VOFFW(VOFFW)) uut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .call_req(call_req), .call_code(call_code),
    .ret_req(ret_req), .ret_legacy(ret_legacy), .ret_target(ret_target),
    .irq_req(irq_req), .irq_vec(irq_vec), .rx_req(rx_req), .rx_set(rx_set), .rx_dst(rx_dst),
    .base_we(base_we), .base_din(base_din), .lock_we(lock_we), .lock_din(lock_din),
    .redirect(redirect), .redirect_pc(redirect_pc), .exc_addr(exc_addr),
    .priv_mode(priv_mode), .intr_flag(intr_flag), .lock_addr(lock_addr),
    .fw_base(fw_base), .rx_wen(rx_wen), .rx_data(rx_data), .rx_dst_q(rx_dst_q)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    call_req = 0; ret_req = 0; ret_legacy = 0; irq_req = 0;
    rx_req = 0; rx_set = 0; rx_dst = 5'd1; base_we = 0; lock_we = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [XLEN-1:0] slot(input logic [XLEN-1:0] b, input int c);
    if (c >= 128) return b + 64'h2000 + 64'(c - 128) * 64;
    return b + 64'h1000 + 64'(c) * 64;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [XLEN-1:0] b, pc, exp_exc, old_exc, old_lock, old_pc;
    logic pm;
    clear_in();
    cur_pc = '0; ret_target = '0; base_din = '0; lock_din = '0; call_code = '0; irq_vec = '0;
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 priv", priv_mode, 1);
    chk("R1 intr", intr_flag, 0);
    chk("R1 lock", lock_addr, '1);
    chk("R1 redirect", redirect, 0);
    chk("R1 exc", exc_addr, 0);
    chk("R1 rx_wen", rx_wen, 0);
    rst_n = 1;

    for (int k = 0; k < 2; k++) begin
      b = (k == 0) ? 64'h0000_0000_8000_0000 : 64'hFFFF_F000_0001_0000;
      base_din = b; base_we = 1; step();
      chk("R12 base", fw_base, b);
      for (int c = 0; c < 256; c++) begin
        pm = c[0];
        ret_req = 1; ret_target = 64'h4000_0000 + 64'(c) * 16 + 64'(pm); step();
        chk("R5 ret mode", priv_mode, pm);
        pc = 64'h1_0000 + 64'(c) * 8 + 64'(c[1]);
        cur_pc = pc; call_code = 8'(c); call_req = 1; step();
        chk("R2 call pc", redirect_pc, slot(b, c));
        chk("R3 exc", exc_addr, pc | 64'(pm));
        chk("R4 priv", priv_mode, 1);
      end
    end

    b = fw_base;
    for (int t = 0; t < 8; t++) begin
      rx_req = 1; rx_set = 1; lock_din = 64'h1234_5670 + 64'(t); lock_we = 1; step();
      chk("R12 lock", lock_addr, 64'h1234_5670 + 64'(t));
      ret_req = 1; ret_target = 64'hABCD_0000_0000_1000 + 64'(t); step();
      chk("R5 ret pc", redirect_pc, (64'hABCD_0000_0000_1000 + 64'(t)) & ~64'h3);
      chk("R5 ret priv", priv_mode, t[0]);
      chk("R6 intr", intr_flag, 0);
      chk("R6 lock", lock_addr, '1);
    end

    ret_req = 1; ret_target = 64'h10; lock_we = 1; lock_din = 64'h77; step();
    chk("R6 lock over load", lock_addr, '1);

    for (int v = 0; v < 2; v++) begin
      ret_req = 1; ret_target = 64'(v); step();
      cur_pc = 64'h9000 + 64'(v) * 4; call_code = 8'h83; call_req = 1; step();
      exp_exc = (64'h9000 + 64'(v) * 4) | 64'(v);
      chk("R3 legacy setup", exc_addr, exp_exc);
      ret_req = 1; ret_legacy = 1; ret_target = 64'hFFFF_FFFF_FFFF_FFF2; step();
      chk("R7 legacy pc", redirect_pc, exp_exc & ~64'h3);
      chk("R7 legacy priv", priv_mode, 64'(v));
    end

    rx_req = 1; rx_set = 1; step();
    lock_din = 64'h5555; lock_we = 1; step();
    ret_req = 1; ret_target = 64'h0; step();
    rx_req = 1; rx_set = 1; step();
    old_exc = exc_addr; old_lock = 64'h5555;
    lock_din = 64'h5555; lock_we = 1; step();
    irq_vec = 16'h0240; irq_req = 1; step();
    chk("R8 irq pc", redirect_pc, b + 64'h240);
    chk("R8 irq priv", priv_mode, 1);
    chk("R8 exc kept", exc_addr, old_exc);
    chk("R8 intr kept", intr_flag, 1);
    chk("R8 lock kept", lock_addr, old_lock);

    ret_req = 1; ret_target = 64'h100; step();
    rx_req = 1; rx_set = 1; step();
    lock_din = 64'h5555; lock_we = 1; step();
    old_exc = exc_addr;
    irq_vec = 16'h0080; irq_req = 1; call_req = 1; call_code = 8'h05; cur_pc = 64'h3333;
    ret_req = 1; ret_target = 64'h2220; step();
    chk("R10 irq wins pc", redirect_pc, b + 64'h80);
    chk("R10 irq wins exc", exc_addr, old_exc);
    chk("R10 irq wins lock", lock_addr, 64'h5555);
    chk("R10 irq wins intr", intr_flag, 1);

    ret_req = 1; ret_target = 64'h200; step();
    rx_req = 1; rx_set = 1; step();
    lock_din = 64'h6666; lock_we = 1; step();
    call_req = 1; call_code = 8'hFF; cur_pc = 64'h4444; ret_req = 1; ret_target = 64'h2220; step();
    chk("R10 call wins pc", redirect_pc, slot(b, 255));
    chk("R10 call wins priv", priv_mode, 1);
    chk("R10 call wins exc", exc_addr, 64'h4444);
    chk("R10 call wins lock", lock_addr, 64'h6666);
    chk("R10 call wins intr", intr_flag, 1);

    for (int s = 0; s < 4; s++) begin
      rx_req = 1; rx_set = s[0]; rx_dst = 5'd3; step();
      old_pc = 64'(s[0]);
      rx_req = 1; rx_set = s[1]; rx_dst = (s == 2) ? 5'd31 : 5'(s + 4); step();
      chk("R9 rx data", rx_data, old_pc);
      chk("R9 rx wen", rx_wen, (s == 2) ? 0 : 1);
      chk("R9 rx dst", rx_dst_q, (s == 2) ? 31 : 64'(s + 4));
      chk("R9 flag", intr_flag, 64'(s[1]));
    end

    rx_req = 1; rx_set = 1; step();
    ret_req = 1; ret_target = 64'h8; rx_req = 1; rx_set = 1; rx_dst = 5'd9; step();
    chk("R11 old flag", rx_data, 1);
    chk("R11 flag cleared", intr_flag, 0);
    chk("R11 wen", rx_wen, 1);
    step();
    chk("R10 idle no redirect", redirect, 0);

    done = 1;
    summary();
  end
endmodule